// File: doc/BRIEF.md
# Physical Address Region Router

This block sits behind a CPU load/store port once translation is done. It takes one physical 32-bit address per transaction and sends it to one of five downstream targets over a single shared request bus. The targets are a control-space sub-decoder, main RAM, an interleaved video RAM window, a boot ROM window and a generic I/O port split into 4 KB pages. Byte, word and long accesses are single transfers. A quad access becomes two long transfers. Narrow reads are sign-extended. Some outcomes are settled inside the router and never reach a target: zero returns, undecoded control space and writes to the read-only window.

The state machine has four states. IDLE accepts a request. LO runs the first (or only) transfer. HI runs the second half of a quad. RESP presents the response for one cycle. The transitions are: accept (IDLE to LO, on req_valid), single_done (LO to RESP, when a non-quad half resolves), lo_done (LO to HI, when the low half of a quad resolves), hi_done (HI to RESP) and deliver (RESP to IDLE). A half resolves when the target acknowledges it, or in its first cycle if the router settles it locally.

Size codes: 0 byte, 1 word, 2 long, 3 quad. Target codes on dn_target: 0 control, 1 main RAM, 2 video RAM, 3 boot ROM, 4 paged I/O.

Top module: `addr_region_router`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, halt_err and dn_valid are 0. req_ready is 1 only in IDLE. Each accepted request gives exactly one rsp_valid pulse, one cycle wide, and the router is ready again in the next cycle.
- R2: An address at or above 0xE0000000 whose bits 28:24 are 0x10 to 0x17 goes to target 0 with dn_csel equal to bits 28:24 minus 0x10. The codes are: 0 instruction-cache address, 1 instruction-cache data, 2 instruction TLB address, 3 instruction TLB data, 4 operand-cache address, 5 operand-cache data, 6 unified TLB address, 7 unified TLB data. dn_addr carries the full address.
- R3: In control space with bits 28:24 equal to 0x00 to 0x03, a read returns zero without a downstream transfer or warning. A write goes to target 0 with dn_csel 8 (store queue).
- R4: Any other control-space access makes no transfer, returns zero and sets rsp_warn.
- R5: Outside control space, when (addr & 0x1C000000) equals 0x0C000000, the access goes to target 1 with dn_addr equal to addr[23:0], zero-extended.
- R6: Otherwise, when (addr & 0x1F800000) equals 0x04000000, the access goes to target 2 at ((a & 0x00FFFFF8) >> 1) | ((a & 4) << 20) | (a & 3) | 0x05000000.
- R7: Otherwise, when addr[28:0] is below 0x200000, a read goes to target 3 at addr[28:0]. A write makes no transfer and sets halt_err. halt_err stays set until reset and never blocks later requests.
- R8: A byte read returns dn_rdata[7:0] sign-extended to 32 bits. A word read returns dn_rdata[15:0] sign-extended to 32 bits. In both cases rsp_rdata[63:32] is 0. Write responses carry zero data.
- R9: All other addresses go to target 4 at {3'b000, addr[28:0]}. The page index is bits 28:12 and the offset is bits 11:0. A read that the port answers with dn_miss returns zero and sets rsp_warn.
- R10: A write that target 4 answers with dn_miss is dropped. It sets rsp_warn unless addr[28:24] is 4, 5 or 6.
- R11: A quad makes two long halves, addr first and then addr+4. Each half is decoded on its own and carries wdata[31:0] and wdata[63:32] respectively. A quad read returns {high half, low half}.
- R12: dn_valid, dn_addr, dn_target, dn_csel, dn_write, dn_size and dn_wdata hold until dn_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router idle, request accepted this cycle |
| req_addr | input | 32 | Physical address |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 quad |
| req_wdata | input | 64 | Store data; low 32 bits for non-quad |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Load result |
| rsp_warn | output | 1 | Undecoded or missing-page outcome in this transaction |
| halt_err | output | 1 | Sticky read-only write trap |
| dn_valid | output | 1 | Downstream transfer request |
| dn_ack | input | 1 | Downstream transfer complete |
| dn_target | output | 3 | Selected target code |
| dn_csel | output | 4 | Control-space array select, 8 for store queue |
| dn_addr | output | 32 | Target-local address |
| dn_write | output | 1 | Transfer direction |
| dn_size | output | 2 | Transfer size (quad halves are long) |
| dn_wdata | output | 32 | Transfer write data |
| dn_rdata | input | 32 | Transfer read data |
| dn_miss | input | 1 | Paged port reports an unmapped page |

## Verification
Decoding each quad half separately means two different outcomes can occur inside one transaction. The clearest case is a quad write at 0x001FFFFC. Its low half raises the read-only trap with no transfer, while its high half at 0x00200000 becomes a paged write in the same transaction. A quad read at 0xE3FFFFFC works the same way: its low half is a silent store-queue zero and its high half is an undecoded warning. The bench runs these next to plain sweeps and checks the transfer log, halt_err, rsp_warn and the combined data against values computed from the address arithmetic. It repeats them with a delayed dn_ack so that a pending transfer overlaps the state change.

// File: rtl/arr_pkg.sv
package arr_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int QDATA_W   = 2 * DATA_W;
    localparam int PHYS_W    = 29;
    localparam int SEG_HI    = 28;
    localparam int SEG_LO    = 24;
    localparam int SEG_W     = SEG_HI - SEG_LO + 1;
    localparam int MRAM_OFF_W = 24;
    localparam int VWIN_W    = 24;
    localparam int CSEL_W    = 4;
    localparam int TGT_W     = 3;

    localparam logic [ADDR_W-1:0] CTRL_BASE  = 32'hE000_0000;
    localparam logic [ADDR_W-1:0] MRAM_MASK  = 32'h1C00_0000;
    localparam logic [ADDR_W-1:0] MRAM_MATCH = 32'h0C00_0000;
    localparam logic [ADDR_W-1:0] VWIN_MASK  = 32'h1F80_0000;
    localparam logic [ADDR_W-1:0] VWIN_MATCH = 32'h0400_0000;
    localparam logic [PHYS_W-1:0] ROM_LIMIT  = 29'h020_0000;
    localparam logic [7:0]        VRAM_TOP   = 8'h05;
    localparam logic [CSEL_W-1:0] CSEL_SQ    = 4'd8;
    localparam logic [ADDR_W-1:0] HALF_STEP  = 32'd4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_QUAD = 2'd3
    } size_e;

    typedef enum logic [TGT_W-1:0] {
        TG_CTRL = 3'd0,
        TG_MRAM = 3'd1,
        TG_VRAM = 3'd2,
        TG_ROM  = 3'd3,
        TG_IO   = 3'd4
    } tgt_e;

    typedef enum logic [1:0] {
        ACT_ACCESS    = 2'd0,
        ACT_ZERO      = 2'd1,
        ACT_ZERO_WARN = 2'd2,
        ACT_TRAP      = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_RESP = 2'd3
    } st_e;

    typedef struct packed {
        act_e               act;
        tgt_e               tgt;
        logic [CSEL_W-1:0]  csel;
        logic [ADDR_W-1:0]  daddr;
    } route_t;

endpackage

// File: rtl/arr_vram_remap.sv
module arr_vram_remap
    import arr_pkg::*;
(
    input  logic [VWIN_W-1:0] win_off,
    output logic [ADDR_W-1:0] dev_addr
);

    // Interleaved window: bit 2 selects the 32-bit bank and moves to bit 22,
    // the remaining line bits shift down by one, the byte lanes stay put.
    always_comb begin
        dev_addr = {VRAM_TOP,
                    1'b0,
                    win_off[2] | win_off[23],
                    win_off[22:3],
                    win_off[1:0]};
    end

endmodule

// File: rtl/arr_rd_format.sv
module arr_rd_format
    import arr_pkg::*;
(
    input  size_e             size,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] val
);

    always_comb begin
        unique case (size)
            SZ_BYTE: val = {{(DATA_W-8){raw[7]}}, raw[7:0]};
            SZ_WORD: val = {{(DATA_W-16){raw[15]}}, raw[15:0]};
            default: val = raw;
        endcase
    end

endmodule

// File: rtl/arr_decode.sv
module arr_decode
    import arr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output route_t            route
);

    logic [ADDR_W-1:0] remapped;
    logic [SEG_W-1:0]  seg;
    logic [PHYS_W-1:0] low;

    arr_vram_remap u_remap (
        .win_off (addr[VWIN_W-1:0]),
        .dev_addr(remapped)
    );

    always_comb begin
        seg = addr[SEG_HI:SEG_LO];
        low = addr[PHYS_W-1:0];

        route.act   = ACT_ACCESS;
        route.tgt   = TG_IO;
        route.csel  = '0;
        route.daddr = {{(ADDR_W-PHYS_W){1'b0}}, low};

        if (addr >= CTRL_BASE) begin
            // control space: array select, store queue, or undecoded
            route.tgt   = TG_CTRL;
            route.daddr = addr;
            if (seg[4:3] == 2'b10) begin
                route.csel = {1'b0, seg[2:0]};
            end else if (seg[4:2] == 3'b000) begin
                if (write) begin
                    route.csel = CSEL_SQ;
                end else begin
                    route.act = ACT_ZERO;
                end
            end else begin
                route.act = ACT_ZERO_WARN;
            end
        end else if ((addr & MRAM_MASK) == MRAM_MATCH) begin
            route.tgt   = TG_MRAM;
            route.daddr = {{(ADDR_W-MRAM_OFF_W){1'b0}}, addr[MRAM_OFF_W-1:0]};
        end else if ((addr & VWIN_MASK) == VWIN_MATCH) begin
            route.tgt   = TG_VRAM;
            route.daddr = remapped;
        end else if (low < ROM_LIMIT) begin
            if (write) begin
                route.act = ACT_TRAP;
            end else begin
                route.tgt = TG_ROM;
            end
        end
    end

endmodule

// File: rtl/addr_region_router.sv
module addr_region_router
    import arr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_addr,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [63:0]        req_wdata,
    output logic               rsp_valid,
    output logic [63:0]        rsp_rdata,
    output logic               rsp_warn,
    output logic               halt_err,
    output logic               dn_valid,
    input  logic               dn_ack,
    output logic [2:0]         dn_target,
    output logic [3:0]         dn_csel,
    output logic [31:0]        dn_addr,
    output logic               dn_write,
    output logic [1:0]         dn_size,
    output logic [31:0]        dn_wdata,
    input  logic [31:0]        dn_rdata,
    input  logic               dn_miss
);

    st_e                st, st_nxt;
    logic [ADDR_W-1:0]  addr_q;
    logic               write_q;
    size_e              size_q;
    logic [QDATA_W-1:0] wdata_q;
    logic [DATA_W-1:0]  lo_q, hi_q;
    logic               warn_q, halt_q;

    logic [ADDR_W-1:0]  cur_addr;
    route_t             rt;
    size_e              half_sz;
    logic [DATA_W-1:0]  fmt_val;
    logic [DATA_W-1:0]  half_val;
    logic               in_half, half_done, half_warn, half_trap;
    logic               io_miss, quiet_seg, accept;

    // ---------------------------------------------------------------
    // Current half address and its decode
    // ---------------------------------------------------------------
    assign cur_addr = (st == ST_HI) ? addr_q + HALF_STEP : addr_q;

    arr_decode u_dec (
        .addr (cur_addr),
        .write(write_q),
        .route(rt)
    );

    assign half_sz = (size_q == SZ_QUAD) ? SZ_LONG : size_q;

    arr_rd_format u_fmt (
        .size(half_sz),
        .raw (dn_rdata),
        .val (fmt_val)
    );

    // ---------------------------------------------------------------
    // Half resolution
    // ---------------------------------------------------------------
    always_comb begin
        in_half   = (st == ST_LO) || (st == ST_HI);
        accept    = (st == ST_IDLE) && req_valid;
        io_miss   = dn_miss && (rt.tgt == TG_IO);
        quiet_seg = (cur_addr[SEG_HI:SEG_LO] >= 5'd4) &&
                    (cur_addr[SEG_HI:SEG_LO] <= 5'd6);
        half_done = in_half && ((rt.act != ACT_ACCESS) || dn_ack);
        half_trap = in_half && (rt.act == ACT_TRAP);
        half_warn = in_half &&
                    ((rt.act == ACT_ZERO_WARN) ||
                     ((rt.act == ACT_ACCESS) && dn_ack && io_miss &&
                      (!write_q || !quiet_seg)));
        if ((rt.act == ACT_ACCESS) && !io_miss && !write_q) begin
            half_val = fmt_val;
        end else begin
            half_val = '0;
        end
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // ---------------------------------------------------------------
    // Next state
    // ---------------------------------------------------------------
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (req_valid) st_nxt = ST_LO;                 // accept
            ST_LO: begin
                if (half_done) begin
                    if (size_q == SZ_QUAD) st_nxt = ST_HI;          // lo_done
                    else                   st_nxt = ST_RESP;        // single_done
                end
            end
            ST_HI:   if (half_done) st_nxt = ST_RESP;               // hi_done
            ST_RESP: st_nxt = ST_IDLE;                              // deliver
        endcase
    end

    // ---------------------------------------------------------------
    // Transaction datapath
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            size_q  <= SZ_BYTE;
            wdata_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            warn_q  <= 1'b0;
            halt_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                write_q <= req_write;
                size_q  <= size_e'(req_size);
                wdata_q <= req_wdata;
                lo_q    <= '0;
                hi_q    <= '0;
                warn_q  <= 1'b0;
            end
            if (half_done) begin
                if (st == ST_LO) lo_q <= half_val;
                else             hi_q <= half_val;
                warn_q <= warn_q | half_warn;
            end
            if (half_trap) begin
                halt_q <= 1'b1;
            end
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        req_ready = (st == ST_IDLE);
        rsp_valid = (st == ST_RESP);
        rsp_rdata = {hi_q, lo_q};
        rsp_warn  = warn_q;
        halt_err  = halt_q;
        dn_valid  = in_half && (rt.act == ACT_ACCESS);
        dn_target = rt.tgt;
        dn_csel   = rt.csel;
        dn_addr   = rt.daddr;
        dn_write  = write_q;
        dn_size   = half_sz;
        dn_wdata  = (st == ST_HI) ? wdata_q[QDATA_W-1:DATA_W] : wdata_q[DATA_W-1:0];
    end

endmodule

// File: rtl/addr_region_router_chk.sv
module addr_region_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        halt_err,
    input logic        dn_valid,
    input logic        dn_ack,
    input logic [2:0]  dn_target,
    input logic [3:0]  dn_csel,
    input logic [31:0] dn_addr,
    input logic        dn_write
);

    a_r1_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    a_r1_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !req_ready);

    a_r2_csel_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_target == 3'd0) |-> (dn_csel <= 4'd8));

    a_r5_mram_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_target == 3'd1) |-> (dn_addr[31:24] == 8'h00));

    a_r6_vram_window: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_target == 3'd2) |-> (dn_addr[31:23] == 9'h00A));

    a_r7_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_write) |-> (dn_target != 3'd3));

    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt_err |=> halt_err);

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ack) |=> dn_valid && $stable(dn_addr) &&
                                  $stable(dn_target) && $stable(dn_csel));

endmodule

bind addr_region_router addr_region_router_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .halt_err (halt_err),
    .dn_valid (dn_valid),
    .dn_ack   (dn_ack),
    .dn_target(dn_target),
    .dn_csel  (dn_csel),
    .dn_addr  (dn_addr),
    .dn_write (dn_write)
);

// File: tb/addr_region_router_tb.sv
`timescale 1ns/1ps
module addr_region_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_warn;
    logic        halt_err;
    logic        dn_valid;
    logic        dn_ack;
    logic [2:0]  dn_target;
    logic [3:0]  dn_csel;
    logic [31:0] dn_addr;
    logic        dn_write;
    logic [1:0]  dn_size;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata;
    logic        dn_miss;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_halt = 0;
    int ack_delay = 0;
    logic [2:0] wait_cnt;

    always #2 clk = ~clk;

    addr_region_router u_dut (.*);

    // ---------------- downstream model ----------------
    function automatic logic [31:0] mdl(input int tg, input logic [31:0] da);
        return da ^ 32'h9C3E_71A5 ^ (32'(tg) * 32'h0101_0101);
    endfunction

    assign dn_rdata = mdl(int'(dn_target), dn_addr);
    assign dn_miss  = (dn_target == 3'd4) && (dn_addr[15:12] == 4'hF);
    assign dn_ack   = dn_valid && (wait_cnt == ack_delay[2:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) wait_cnt <= '0;
        else if (dn_valid && !dn_ack) wait_cnt <= wait_cnt + 3'd1;
        else wait_cnt <= '0;
    end

    int          log_n = 0;
    int          lg_tg [1024];
    int          lg_cs [1024];
    logic [31:0] lg_da [1024];
    logic        lg_w  [1024];
    int          lg_sz [1024];
    logic [31:0] lg_wd [1024];

    always @(posedge clk) begin
        if (rst_n && dn_valid && dn_ack) begin
            lg_tg[log_n % 1024] <= int'(dn_target);
            lg_cs[log_n % 1024] <= int'(dn_csel);
            lg_da[log_n % 1024] <= dn_addr;
            lg_w [log_n % 1024] <= dn_write;
            lg_sz[log_n % 1024] <= int'(dn_size);
            lg_wd[log_n % 1024] <= dn_wdata;
            log_n <= log_n + 1;
        end
    end

    // ---------------- reference arithmetic ----------------
    // act: 0 transfer, 1 silent zero, 2 zero with warning, 3 trap
    function automatic void exp_route(input logic [31:0] a, input bit w,
                                      output int act, output int tg,
                                      output int cs, output logic [31:0] da);
        int seg;
        seg = int'(a[28:24]);
        act = 0; tg = 4; cs = 0; da = a & 32'h1FFF_FFFF;
        if (a >= 32'hE000_0000) begin
            tg = 0; da = a;
            if (seg >= 16 && seg <= 23) cs = seg - 16;
            else if (seg <= 3) begin
                if (w) cs = 8; else act = 1;
            end else act = 2;
        end else if ((a & 32'h1C00_0000) == 32'h0C00_0000) begin
            tg = 1; da = a & 32'h00FF_FFFF;
        end else if ((a & 32'h1F80_0000) == 32'h0400_0000) begin
            tg = 2;
            da = ((a & 32'h00FF_FFF8) >> 1) | ((a & 32'h4) << 20) |
                 (a & 32'h3) | 32'h0500_0000;
        end else if ((a & 32'h1FFF_FFFF) < 32'h0020_0000) begin
            if (w) act = 3; else tg = 3;
        end
    endfunction

    function automatic logic [31:0] fmt(input int s, input logic [31:0] r);
        if (s == 0) return {{24{r[7]}}, r[7:0]};
        if (s == 1) return {{16{r[15]}}, r[15:0]};
        return r;
    endfunction

    function automatic string pick_tag(input int act, input int tg, input int cs, input bit w);
        if (act == 3) return "R7 trap";
        if (act == 2) return "R4 ctrl undecoded";
        if (act == 1) return "R3 sq read";
        if (tg == 0)  return (cs == 8) ? "R3 sq write" : "R2 ctrl array";
        if (tg == 1)  return "R5 main ram";
        if (tg == 2)  return "R6 video remap";
        if (tg == 3)  return "R7 rom read";
        return w ? "R10 paged write" : "R9 paged read";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_txn(input logic [31:0] a, input bit w, input int sz, input logic [63:0] wd);
        int          nh, e_n, start, guard;
        int          e_tg [2];
        int          e_cs [2];
        logic [31:0] e_da [2];
        logic [31:0] e_wd [2];
        logic [31:0] vals [2];
        logic [63:0] e_rd;
        bit          e_warn;
        string       tag, pre;
        nh = (sz == 3) ? 2 : 1;
        e_n = 0; e_warn = 0; vals[0] = '0; vals[1] = '0; tag = "";
        pre = (sz == 3) ? "R11 " : "";
        if (ack_delay > 0) pre = {"R12 ", pre};
        for (int h = 0; h < nh; h++) begin
            logic [31:0] ah, da;
            int act, tg, cs;
            bit miss;
            ah = a + 32'(4 * h);
            exp_route(ah, w, act, tg, cs, da);
            tag = {tag, pick_tag(act, tg, cs, w), " "};
            if (act == 0) begin
                miss = (tg == 4) && (da[15:12] == 4'hF);
                e_tg[e_n] = tg; e_cs[e_n] = cs; e_da[e_n] = da;
                e_wd[e_n] = (h == 1) ? wd[63:32] : wd[31:0];
                e_n++;
                if (!w && !miss) vals[h] = fmt((sz == 3) ? 2 : sz, mdl(tg, da));
                if (miss && (!w || !(ah[28:24] >= 5'd4 && ah[28:24] <= 5'd6))) e_warn = 1;
            end else if (act == 2) e_warn = 1;
            else if (act == 3) exp_halt = 1;
        end
        tag = {pre, tag};
        start = log_n;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_size = 2'(sz); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1 busy after accept", 64'(req_ready), 64'd0);
        guard = 0;
        while (!rsp_valid && guard < 64) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 64, {"R1 response ", tag}, 64'(guard), 64'd0);
        chk(log_n - start == e_n, {tag, "transfer count"}, 64'(log_n - start), 64'(e_n));
        for (int i = 0; i < e_n && i < (log_n - start); i++) begin
            int k;
            k = (start + i) % 1024;
            chk(lg_tg[k] == e_tg[i], {tag, "target"}, 64'(lg_tg[k]), 64'(e_tg[i]));
            chk(lg_cs[k] == e_cs[i], {tag, "csel"}, 64'(lg_cs[k]), 64'(e_cs[i]));
            chk(lg_da[k] == e_da[i], {tag, "addr"}, 64'(lg_da[k]), 64'(e_da[i]));
            chk(lg_w[k] == w, {tag, "dir"}, 64'(lg_w[k]), 64'(w));
            chk(lg_sz[k] == ((sz == 3) ? 2 : sz), {tag, "size"}, 64'(lg_sz[k]), 64'(sz));
            if (w) chk(lg_wd[k] == e_wd[i], {tag, "wdata"}, 64'(lg_wd[k]), 64'(e_wd[i]));
        end
        e_rd = w ? 64'd0 : {vals[1], vals[0]};
        chk(rsp_rdata == e_rd, {(sz < 2) ? "R8 " : "", tag, "rdata"}, rsp_rdata, e_rd);
        chk(rsp_warn == e_warn, {tag, "warn"}, 64'(rsp_warn), 64'(e_warn));
        chk(halt_err == exp_halt, {"R7 halt ", tag}, 64'(halt_err), 64'(exp_halt));
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready after response",
            64'({req_ready, rsp_valid}), 64'd2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(halt_err == 1'b0, "R1 reset halt", 64'(halt_err), 64'd0);
        chk(dn_valid == 1'b0, "R1 reset dn_valid", 64'(dn_valid), 64'd0);
        rst_n = 1'b1;
        exp_halt = 0;
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        do_reset();

        // control space: every bits 28:24 value, both directions (R2 R3 R4)
        for (int seg = 0; seg < 32; seg++) begin
            for (int w = 0; w < 2; w++) begin
                do_txn(32'hE000_0000 | (32'(seg) << 24) | 32'h0003_A5C4, bit'(w), 2,
                       64'h1357_9BDF_2468_ACE0 ^ 64'(seg));
            end
        end

        // sweep over bits 28:23 with aliased upper bits, all sizes (R5..R10)
        for (int t = 0; t < 64; t++) begin
            for (int w = 0; w < 2; w++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    logic [31:0] a;
                    logic [2:0]  top;
                    logic [5:0]  t6;
                    top = 3'(t % 7);
                    t6  = 6'(t);
                    a = {top, t6, 7'h00, t6[3:0], 10'h297 ^ 10'(t * 37), 2'(sz + t)};
                    do_txn(a, bit'(w), sz, {32'hCAFE_0000 | 32'(t), 32'h8123_4567 ^ 32'(t * 97)});
                end
            end
        end

        // missing-page write quiet range and warnings (R10 R9)
        do_txn(32'h0600_F000, 1'b1, 2, 64'h0000_0000_1111_2222);
        do_txn(32'h0480_F004, 1'b1, 1, 64'h0000_0000_3333_4444);
        do_txn(32'h0500_F008, 1'b1, 0, 64'h0000_0000_5555_6666);
        do_txn(32'h0700_F000, 1'b1, 2, 64'h0000_0000_7777_8888);
        do_txn(32'h0700_F000, 1'b0, 2, 64'h0);
        do_txn(32'h0500_F00C, 1'b0, 0, 64'h0);

        do_reset();

        // quads, with and without delayed acknowledge (R11 R12)
        for (int d = 0; d < 3; d++) begin
            ack_delay = (d == 2) ? 3 : d;
            do_txn(32'h0C00_1000, 1'b0, 3, 64'h0);
            do_txn(32'h0C00_1000, 1'b1, 3, 64'hDEAD_BEEF_0BAD_F00D);
            do_txn(32'h0400_0010, 1'b0, 3, 64'h0);
            do_txn(32'h0400_0014, 1'b1, 3, 64'h0123_4567_89AB_CDEF);
            do_txn(32'h001F_FFFC, 1'b0, 3, 64'h0);
            do_txn(32'hE3FF_FFFC, 1'b0, 3, 64'h0);
            do_txn(32'hE3FF_FFFC, 1'b1, 3, 64'hAAAA_5555_CCCC_3333);
            do_txn(32'h1000_EFFC, 1'b0, 3, 64'h0);
            do_txn(32'h0001_0000, 1'b0, 1, 64'h0);
            do_txn(32'h001F_FFFC, 1'b1, 3, 64'hFEED_FACE_B0B0_CAFE);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule